// File: doc/BRIEF.md
# Five-Source Priority Interrupt Controller

This block gathers five interrupt requests for a small 8-bit processor core and decides which one, if any, is taken when the core finishes an instruction. The core pulses an end-of-instruction strobe. If an eligible request is pending at that strobe, the block raises a service request. Along with it, the block presents a 16-bit restart address and asks the core to save its program counter. It holds all of this until the core acknowledges. Software can write a mask for three of the sources and a global enable flag. A status word shows the mask, the enable flag and every pending request.

One source cannot be masked at all. Three sources branch to fixed addresses. The lowest source has no address of its own. For that source the block drives an active-low acknowledge line, so that the requesting device can place the instruction to run on the bus. The stack push and the instruction execution belong to the core and are not part of this block.

Top module: `intc5_top`

## Requirements
- R1: After reset, no request is raised, `ack_n_o` is 1, `vec_o` is 0, the global enable is 0 and all three mask bits are 1 (blocked).
- R2: When several sources are eligible, only the highest is taken. The order from highest to lowest is: non-maskable, A, B, C, general.
- R3: The restart address is 0x0024 for the non-maskable source, 0x003C for A, 0x0034 for B and 0x002C for C. It is 0x0000 for the general source.
- R4: A pending non-maskable request is taken at the next boundary, whatever the mask bits and the global enable hold.
- R5: Sources A, B and C are taken only when the global enable is 1 and their own mask bit is 0. Mask bit 0 is A, bit 1 is B and bit 2 is C. The general source is taken only when the global enable is 1.
- R6: A request is taken only on a clock edge where `insn_end_i` is 1 and no service request is outstanding.
- R7: `save_pc_o` is 1 whenever, and only when, a service request is raised.
- R8: For the general source, `ext_o` is 1 and `ack_n_o` is 0 while its request is raised. For every other source, `ext_o` is 0 and `ack_n_o` is 1.
- R9: Taking any request clears the global enable. Only a write with `gie_we_i` sets it again.
- R10: The non-maskable source and source A are latched on a rising edge. A latch clears when that source is acknowledged, and a level held high after that does not latch the source again.
- R11: Sources B, C and the general source follow their input level. Any request not taken stays pending and is taken at a later boundary.
- R12: The status word is laid out as follows: bits [2:0] hold the mask, bit 3 holds the global enable, and bits [8:4] hold the pending bits. Bit 4 is the non-maskable source, bit 5 is A, bit 6 is B, bit 7 is C and bit 8 is the general source. The word lags the state by one cycle.
- R13: A raised request keeps its address steady until `cpu_ack_i` is 1. It drops on the edge that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_nmi_i | input | 1 | Non-maskable request, latched on a rising edge |
| irq_a_i | input | 1 | Vectored request A, latched on a rising edge |
| irq_b_i | input | 1 | Vectored request B, level |
| irq_c_i | input | 1 | Vectored request C, level |
| irq_gen_i | input | 1 | General non-vectored request, level |
| insn_end_i | input | 1 | Instruction boundary strobe from the core |
| cpu_ack_i | input | 1 | Core has accepted the service request |
| mask_we_i | input | 1 | Mask write strobe |
| mask_wd_i | input | 3 | New mask bits (1 = blocked) |
| gie_we_i | input | 1 | Global enable write strobe |
| gie_wd_i | input | 1 | New global enable value |
| req_o | output | 1 | Service request to the core |
| vec_o | output | 16 | Restart address |
| save_pc_o | output | 1 | Core must save the next-instruction address |
| ext_o | output | 1 | Taken source supplies its own instruction |
| ack_n_o | output | 1 | Active-low acknowledge to the general requester |
| status_o | output | 9 | Mask, enable and pending bits |

## Verification
A fault in the priority chain or the eligibility logic shows up as the wrong restart address. It appears one edge after the boundary strobe, on the very first boundary that has more than one request pending. A latch that fails to clear after acknowledge, or a global enable flag that is left stuck, shows up in two places. It is visible in the status word two edges after acknowledge. It also shows up as an unexpected second service at the next boundary, once the enable is written back to 1. The sweep covers every pattern of the five requests, with every mask value and both enable values. It then checks a follow-up boundary, so each of these faults surfaces within a few cycles of the case that exposes it.

// File: rtl/icu_pkg.sv
package icu_pkg;
  localparam int SRC_N   = 5;
  localparam int IDX_W   = 3;
  localparam int VEC_W   = 16;
  localparam int MASK_W  = 3;
  localparam int EDGE_N  = 2;
  localparam int ST_W    = SRC_N + 1 + MASK_W;

  localparam logic [IDX_W-1:0] SRC_NMI = 3'd0;
  localparam logic [IDX_W-1:0] SRC_A   = 3'd1;
  localparam logic [IDX_W-1:0] SRC_B   = 3'd2;
  localparam logic [IDX_W-1:0] SRC_C   = 3'd3;
  localparam logic [IDX_W-1:0] SRC_GEN = 3'd4;

  function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
    case (idx)
      SRC_NMI: vec_of = 16'h0024;
      SRC_A:   vec_of = 16'h003C;
      SRC_B:   vec_of = 16'h0034;
      SRC_C:   vec_of = 16'h002C;
      default: vec_of = 16'h0000;
    endcase
  endfunction
endpackage

// File: rtl/icu_edge_cap.sv
module icu_edge_cap #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] rise;

  assign rise = lvl_i & ~prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      pend_o <= '0;
    end else begin
      prev_q <= lvl_i;
      pend_o <= (pend_o & ~clr_i) | rise;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_chk
    // R10: a rising edge always leaves the latch set
    a_r10_edge_sets: assert property (@(posedge clk) disable iff (rst)
      lvl_i[i] && !prev_q[i] |=> pend_o[i]);
    // R10: clearing without a new edge empties the latch
    a_r10_clear: assert property (@(posedge clk) disable iff (rst)
      clr_i[i] && !(lvl_i[i] && !prev_q[i]) |=> !pend_o[i]);
  end
endmodule

// File: rtl/icu_arb.sv
module icu_arb #(
  parameter int N  = 5,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end

  logic [N-1:0] higher;
  assign higher = (N'(1) << idx_o) - N'(1);

  always_comb begin
    if (any_o) begin
      // R2: winner is requesting and nothing above it is
      a_r2_winner: assert ((req_i & higher) == '0 && req_i[idx_o]);
    end
  end
endmodule

// File: rtl/icu_seq.sv
module icu_seq
  import icu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              any_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              insn_end_i,
  input  logic              cpu_ack_i,
  input  logic              mask_we_i,
  input  logic [MASK_W-1:0] mask_wd_i,
  input  logic              gie_we_i,
  input  logic              gie_wd_i,
  output logic              req_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic              save_pc_o,
  output logic              ext_o,
  output logic              ack_n_o,
  output logic              gie_o,
  output logic [MASK_W-1:0] mask_o,
  output logic [EDGE_N-1:0] clr_o
);
  logic [IDX_W-1:0] sel_q;
  logic             take;
  logic             served;

  assign take   = !req_o && insn_end_i && any_i;
  assign served = req_o && cpu_ack_i;
  assign clr_o  = {served && sel_q == SRC_A, served && sel_q == SRC_NMI};

  always_ff @(posedge clk) begin
    if (rst) begin
      req_o     <= 1'b0;
      vec_o     <= '0;
      save_pc_o <= 1'b0;
      ext_o     <= 1'b0;
      ack_n_o   <= 1'b1;
      gie_o     <= 1'b0;
      mask_o    <= '1;
      sel_q     <= '0;
    end else begin
      if (mask_we_i) mask_o <= mask_wd_i;
      if (gie_we_i)  gie_o  <= gie_wd_i;
      if (take) begin
        req_o     <= 1'b1;
        sel_q     <= idx_i;
        vec_o     <= vec_of(idx_i);
        save_pc_o <= 1'b1;
        ext_o     <= (idx_i == SRC_GEN);
        ack_n_o   <= (idx_i != SRC_GEN);
        gie_o     <= 1'b0;
      end else if (served) begin
        req_o     <= 1'b0;
        vec_o     <= '0;
        save_pc_o <= 1'b0;
        ext_o     <= 1'b0;
        ack_n_o   <= 1'b1;
      end
    end
  end

  // R13: request and address hold until acknowledged
  a_r13_hold: assert property (@(posedge clk) disable iff (rst)
    req_o && !cpu_ack_i |=> req_o && $stable(vec_o));
  // R6: a request only appears after a boundary strobe
  a_r6_boundary: assert property (@(posedge clk) disable iff (rst)
    $rose(req_o) |-> $past(insn_end_i));
  // R9: enable is clear once a request is taken
  a_r9_gie_clear: assert property (@(posedge clk) disable iff (rst)
    $rose(req_o) |-> !gie_o);
  // R8: low acknowledge only for the external-instruction source
  a_r8_ackn: assert property (@(posedge clk) disable iff (rst)
    !ack_n_o |-> req_o && ext_o);
  // R7: save request accompanies the service request
  a_r7_save: assert property (@(posedge clk) disable iff (rst)
    save_pc_o == req_o);
  // R3: vectored sources land on one of the fixed addresses
  a_r3_vec: assert property (@(posedge clk) disable iff (rst)
    req_o && !ext_o |-> vec_o inside {16'h0024, 16'h003C, 16'h0034, 16'h002C});
endmodule

// File: rtl/intc5_top.sv
module intc5_top
  import icu_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        irq_nmi_i,
  input  logic        irq_a_i,
  input  logic        irq_b_i,
  input  logic        irq_c_i,
  input  logic        irq_gen_i,
  input  logic        insn_end_i,
  input  logic        cpu_ack_i,
  input  logic        mask_we_i,
  input  logic [2:0]  mask_wd_i,
  input  logic        gie_we_i,
  input  logic        gie_wd_i,
  output logic        req_o,
  output logic [15:0] vec_o,
  output logic        save_pc_o,
  output logic        ext_o,
  output logic        ack_n_o,
  output logic [8:0]  status_o
);
  logic [EDGE_N-1:0] edge_pend;
  logic [EDGE_N-1:0] edge_clr;
  logic [SRC_N-1:0]  pend;
  logic [SRC_N-1:0]  elig;
  logic [MASK_W-1:0] mask;
  logic              gie;
  logic              any;
  logic [IDX_W-1:0]  idx;

  icu_edge_cap #(.W(EDGE_N)) u_edge (
    .clk(clk), .rst(rst),
    .lvl_i({irq_a_i, irq_nmi_i}),
    .clr_i(edge_clr),
    .pend_o(edge_pend)
  );

  assign pend = {irq_gen_i, irq_c_i, irq_b_i, edge_pend};

  always_comb begin
    elig[SRC_NMI] = pend[SRC_NMI];
    for (int k = 0; k < MASK_W; k++) begin
      elig[k + 1] = pend[k + 1] && gie && !mask[k];
    end
    elig[SRC_GEN] = pend[SRC_GEN] && gie;
  end

  icu_arb #(.N(SRC_N), .IW(IDX_W)) u_arb (
    .req_i(elig), .any_o(any), .idx_o(idx)
  );

  icu_seq u_seq (
    .clk(clk), .rst(rst),
    .any_i(any), .idx_i(idx),
    .insn_end_i(insn_end_i), .cpu_ack_i(cpu_ack_i),
    .mask_we_i(mask_we_i), .mask_wd_i(mask_wd_i),
    .gie_we_i(gie_we_i), .gie_wd_i(gie_wd_i),
    .req_o(req_o), .vec_o(vec_o), .save_pc_o(save_pc_o),
    .ext_o(ext_o), .ack_n_o(ack_n_o),
    .gie_o(gie), .mask_o(mask), .clr_o(edge_clr)
  );

  always_ff @(posedge clk) begin
    if (rst) status_o <= {{SRC_N{1'b0}}, 1'b0, {MASK_W{1'b1}}};
    else     status_o <= {pend, gie, mask};
  end

  // R4: a latched non-maskable request is taken at the next free boundary
  a_r4_nmi: assert property (@(posedge clk) disable iff (rst)
    edge_pend[0] && insn_end_i && !req_o |=> req_o && vec_o == 16'h0024);
  // R5: a masked source never wins
  a_r5_masked: assert property (@(posedge clk) disable iff (rst)
    !req_o && insn_end_i && !gie && !pend[SRC_NMI] |=> !req_o);
endmodule

// File: tb/tb_intc5_top.sv
module tb_intc5_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        irq_nmi_i = 0, irq_a_i = 0, irq_b_i = 0, irq_c_i = 0, irq_gen_i = 0;
  logic        insn_end_i = 0, cpu_ack_i = 0;
  logic        mask_we_i = 0, gie_we_i = 0, gie_wd_i = 0;
  logic [2:0]  mask_wd_i = 0;
  logic        req_o, save_pc_o, ext_o, ack_n_o;
  logic [15:0] vec_o;
  logic [8:0]  status_o;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  intc5_top dut (
    .clk(clk), .rst(rst),
    .irq_nmi_i(irq_nmi_i), .irq_a_i(irq_a_i), .irq_b_i(irq_b_i),
    .irq_c_i(irq_c_i), .irq_gen_i(irq_gen_i),
    .insn_end_i(insn_end_i), .cpu_ack_i(cpu_ack_i),
    .mask_we_i(mask_we_i), .mask_wd_i(mask_wd_i),
    .gie_we_i(gie_we_i), .gie_wd_i(gie_wd_i),
    .req_o(req_o), .vec_o(vec_o), .save_pc_o(save_pc_o),
    .ext_o(ext_o), .ack_n_o(ack_n_o), .status_o(status_o)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int winner(input logic [4:0] p, input logic [2:0] m, input logic g);
    if (p[0]) return 0;
    for (int k = 1; k <= 3; k++) if (g && p[k] && !m[k-1]) return k;
    if (g && p[4]) return 4;
    return -1;
  endfunction

  function automatic logic [15:0] exp_vec(input int w);
    case (w)
      0: return 16'h0024;
      1: return 16'h003C;
      2: return 16'h0034;
      3: return 16'h002C;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic check_taken(input int w, input string tag);
    check({tag, " R2 req"}, req_o, 1);
    check({tag, " R3 vec"}, vec_o, exp_vec(w));
    check({tag, " R7 save_pc"}, save_pc_o, 1);
    check({tag, " R8 ext"}, ext_o, (w == 4));
    check({tag, " R8 ack_n"}, ack_n_o, (w != 4));
  endtask

  task automatic acknowledge();
    cpu_ack_i = 1; tick(); cpu_ack_i = 0;
    check("R13 drop after ack", req_o, 0);
    check("R8 ack_n released", ack_n_o, 1);
  endtask

  task automatic run_case(input logic [4:0] p, input logic [2:0] m, input logic g);
    int w1, w2;
    logic [4:0] p2;
    rst = 1; tick(); tick(); rst = 0;
    mask_we_i = 1; mask_wd_i = m; gie_we_i = 1; gie_wd_i = g;
    tick();
    mask_we_i = 0; gie_we_i = 0;
    irq_nmi_i = p[0]; irq_a_i = p[1]; irq_b_i = p[2]; irq_c_i = p[3]; irq_gen_i = p[4];
    tick(); tick(); tick();
    check("R12 status layout", status_o, {p, g, m});
    check("R6 no take without boundary", req_o, 0);
    insn_end_i = 1; tick(); insn_end_i = 0;
    w1 = winner(p, m, g);
    p2 = p;
    if (w1 >= 0) begin
      check_taken(w1, (w1 == 0) ? "R4 first" : "R5 first");
      insn_end_i = 1; tick(); insn_end_i = 0;
      check("R13 held req", req_o, 1);
      check("R13 held vec / R6 busy boundary", vec_o, exp_vec(w1));
      tick();
      check("R9 enable cleared", status_o[3], 0);
      acknowledge();
      if (w1 == 0) p2[0] = 0;
      if (w1 == 1) p2[1] = 0;
      tick(); tick();
      check("R10 R11 pending after ack", status_o[8:4], p2);
    end else begin
      check("R5 nothing eligible", req_o, 0);
    end
    gie_we_i = 1; gie_wd_i = 1; tick(); gie_we_i = 0;
    insn_end_i = 1; tick(); insn_end_i = 0;
    w2 = winner(p2, m, 1'b1);
    if (w2 >= 0) begin
      check_taken(w2, "R11 next boundary");
      acknowledge();
    end else begin
      check("R11 none left", req_o, 0);
    end
    irq_nmi_i = 0; irq_a_i = 0; irq_b_i = 0; irq_c_i = 0; irq_gen_i = 0;
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(); tick();
    rst = 0;
    tick();
    check("R1 req", req_o, 0);
    check("R1 ack_n", ack_n_o, 1);
    check("R1 vec", vec_o, 0);
    check("R1 save_pc", save_pc_o, 0);
    check("R1 status", status_o, 9'b00000_0_111);
    for (int g = 0; g < 2; g++)
      for (int m = 0; m < 8; m++)
        for (int p = 0; p < 32; p++)
          run_case(5'(p), 3'(m), 1'(g));
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule